// File: doc/BRIEF.md
# Dual-width host memory port

This block gives a microprocessor random access to a 1024-word by 24-bit memory. The processor uses it to preload the memory before a processing run, or to read the results afterwards. The data path can be 24 bits wide, or 16 bits wide. In 16-bit mode an extra select line picks either the low 16 bits or the high 8 bits of a word, so a full word needs two accesses. The data bus is bidirectional and is modelled as three signals: an input, an output and an output enable.

The read and write strobes are active low and have no timing relation to the system clock. Each strobe passes through a two-stage synchronizer. Its edges are then detected in the clock domain:

- A read takes its address when the read strobe falls.
- A write takes its address when the write strobe falls, and takes its data and commits when the strobe rises.

While host mode is off, the bus shows the processing pipeline's data, and the read strobe only drives the output enable. A clear input blocks all writes while it is active and forces the host read data to zero.

Top module: `host_mem_port`

## Requirements
- R1: After reset `busOut` is zero and `busOe` is low.
- R2: Each strobe edge acts on the third rising clock edge after the strobe changes, and `busOe` follows `rdN` with the same delay. A read returns the word at the `addr` present when `rdN` fell, provided `addr` is held for three clock cycles after that. Changing `addr` later while `rdN` stays low leaves `busOut` unchanged.
- R3: A write stores to the address present when `wrN` fell. It uses the `busIn` value present when `wrN` rose (both held for three cycles). Address or data changes during the low phase have no effect.
- R4: With `wide`=1, a write stores `busIn[23:0]` and a read returns all 24 bits on `busOut[23:0]`.
- R5: With `wide`=0 and `upperSel`=0, a read puts word bits 15:0 on `busOut[15:0]` and drives `busOut[23:16]` to zero.
- R6: With `wide`=0 and `upperSel`=1, a read puts word bits 23:16 on `busOut[7:0]` and drives `busOut[23:8]` to zero.
- R7: A 16-bit write uses the same slices as the reads in R5 and R6. With `upperSel`=0, word bits 15:0 take `busIn[15:0]`. With `upperSel`=1, word bits 23:16 take `busIn[7:0]`. The other word bits are left unchanged.
- R8: With `hostMode`=0, `busOut` equals `pipeData` and strobes write nothing. Only the output enable still follows `rdN`.
- R9: While `clearN` is low, writes take no effect, and a read captured then gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clearN | input | 1 | Clear, active low: blocks writes, zeroes read data |
| hostMode | input | 1 | 1 = host access active, 0 = pipeline drives the bus |
| wide | input | 1 | 1 = 24-bit bus, 0 = 16-bit bus |
| rdN | input | 1 | Read strobe, active low; output enable in all modes |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 10 | Host word address |
| upperSel | input | 1 | 16-bit mode slice select: 0 = low 16 bits, 1 = high 8 bits |
| busIn | input | 24 | Data bus, input side |
| pipeData | input | 24 | Pipeline value shown on the bus outside host mode |
| busOut | output | 24 | Data bus, output side |
| busOe | output | 1 | Data bus output enable |

## Verification
The bench builds the block with its default parameters: a 10-bit address, a 24-bit word, a 16-bit narrow width and two synchronizer stages. This keeps the three-cycle strobe-to-action delay fixed, so a behavioural model can be compared against it on every clock. These parameter values bring both end addresses, 0 and 1023, within reach. They also make the 8-bit upper slice a real partial word, so the merge in 16-bit writes can be observed through a wide read-back.

// File: rtl/hostPortPkg.sv
package hostPortPkg;

  // Single-cycle strobes from the control half to the datapath half.
  typedef struct packed {
    logic rdFall;   // read strobe has just gone active
    logic wrFall;   // write strobe has just gone active
    logic wrRise;   // write strobe has just been released
    logic clrAct;   // synchronized clear is active
  } portStrobes_t;

endpackage

// File: rtl/hostPortCtrl.sv
module hostPortCtrl
  import hostPortPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rdN,
  input  logic         wrN,
  input  logic         clearN,
  output portStrobes_t strobes,
  output logic         rdActive
);

  // One extra stage past the synchronizer holds the previous level.
  localparam int TAP = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0]   rdPipe;
  logic [SYNC_STAGES:0]   wrPipe;
  logic [SYNC_STAGES-1:0] clrPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPipe  <= '1;
      wrPipe  <= '1;
      clrPipe <= '1;
    end else begin
      rdPipe  <= {rdPipe[SYNC_STAGES-1:0], rdN};
      wrPipe  <= {wrPipe[SYNC_STAGES-1:0], wrN};
      clrPipe <= {clrPipe[SYNC_STAGES-2:0], clearN};
    end
  end

  logic rdSync, rdOld, wrSync, wrOld;

  always_comb begin
    rdSync = rdPipe[TAP];
    rdOld  = rdPipe[SYNC_STAGES];
    wrSync = wrPipe[TAP];
    wrOld  = wrPipe[SYNC_STAGES];
    strobes.rdFall = rdOld & ~rdSync;
    strobes.wrFall = wrOld & ~wrSync;
    strobes.wrRise = ~wrOld & wrSync;
    strobes.clrAct = ~clrPipe[TAP];
    rdActive       = ~rdOld;
  end

  // R3: a write release is only ever seen after the matching activation
  a_r3_rise_after_low: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrRise |-> $past(!wrSync));

endmodule

// File: rtl/hostPortData.sv
module hostPortData
  import hostPortPkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostMode,
  input  logic              wide,
  input  logic              upperSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] pipeData,
  input  portStrobes_t      strobes,
  output logic [DATA_W-1:0] busOut
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int UPPER_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] readReg;
  logic [ADDR_W-1:0] wrAddrQ;
  logic              wrUpQ;
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] oldWord;
  logic [DATA_W-1:0] newWord;
  logic              doWrite;

  // Place the selected slice of a word on the low bus lines, rest zero.
  function automatic logic [DATA_W-1:0] shapeRead(
    input logic [DATA_W-1:0] word, input logic wideSel, input logic up);
    logic [DATA_W-1:0] r;
    r = '0;
    if (wideSel) r = word;
    else if (up) r[UPPER_W-1:0] = word[DATA_W-1:NARROW_W];
    else         r[NARROW_W-1:0] = word[NARROW_W-1:0];
    return r;
  endfunction

  // Overlay the incoming bus slice onto the stored word.
  function automatic logic [DATA_W-1:0] mergeWrite(
    input logic [DATA_W-1:0] old, input logic [DATA_W-1:0] din,
    input logic wideSel, input logic up);
    logic [DATA_W-1:0] r;
    r = old;
    if (wideSel) r = din;
    else if (up) r[DATA_W-1:NARROW_W] = din[UPPER_W-1:0];
    else         r[NARROW_W-1:0] = din[NARROW_W-1:0];
    return r;
  endfunction

  always_comb begin
    rdWord  = mem[addr];
    oldWord = mem[wrAddrQ];
    newWord = mergeWrite(oldWord, busIn, wide, wrUpQ);
    doWrite = hostMode & strobes.wrRise & ~strobes.clrAct;
    busOut  = hostMode ? readReg : pipeData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readReg <= '0;
      wrAddrQ <= '0;
      wrUpQ   <= 1'b0;
    end else begin
      if (strobes.clrAct) readReg <= '0;
      else if (hostMode && strobes.rdFall) readReg <= shapeRead(rdWord, wide, upperSel);
      if (hostMode && strobes.wrFall) begin
        wrAddrQ <= addr;
        wrUpQ   <= upperSel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrAddrQ] <= newWord;
  end

  // R9: clear forces the read data to zero
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrAct |=> readReg == '0);

  // R9: a release during clear leaves the addressed word untouched
  a_r9_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (hostMode && strobes.wrRise && strobes.clrAct) |=> oldWord == $past(oldWord));

  // R5: low-slice read leaves the upper bus lines at zero
  a_r5_lower_slice: assert property (@(posedge clk) disable iff (!rstN)
    (hostMode && strobes.rdFall && !strobes.clrAct && !wide && !upperSel)
      |=> readReg[DATA_W-1:NARROW_W] == '0);

  // R6: high-slice read uses only the lowest UPPER_W lines
  a_r6_upper_slice: assert property (@(posedge clk) disable iff (!rstN)
    (hostMode && strobes.rdFall && !strobes.clrAct && !wide && upperSel)
      |=> readReg[DATA_W-1:UPPER_W] == '0);

  // R7: narrow low write keeps the high bits
  a_r7_keep_high: assert property (@(posedge clk) disable iff (!rstN)
    (doWrite && !wide && !wrUpQ)
      |=> oldWord[DATA_W-1:NARROW_W] == $past(oldWord[DATA_W-1:NARROW_W]));

  // R7: narrow high write keeps the low bits
  a_r7_keep_low: assert property (@(posedge clk) disable iff (!rstN)
    (doWrite && !wide && wrUpQ)
      |=> oldWord[NARROW_W-1:0] == $past(oldWord[NARROW_W-1:0]));

endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
  import hostPortPkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 24,
  parameter int NARROW_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearN,
  input  logic              hostMode,
  input  logic              wide,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              upperSel,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] pipeData,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe
);

  portStrobes_t strobes;

  hostPortCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdN      (rdN),
    .wrN      (wrN),
    .clearN   (clearN),
    .strobes  (strobes),
    .rdActive (busOe)
  );

  hostPortData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .hostMode (hostMode),
    .wide     (wide),
    .upperSel (upperSel),
    .addr     (addr),
    .busIn    (busIn),
    .pipeData (pipeData),
    .strobes  (strobes),
    .busOut   (busOut)
  );

endmodule

// File: tb/host_mem_port_tb.sv
module host_mem_port_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clearN = 1'b1;
  logic        hostMode = 1'b1;
  logic        wide = 1'b1;
  logic        rdN = 1'b1;
  logic        wrN = 1'b1;
  logic [9:0]  addr = '0;
  logic        upperSel = 1'b0;
  logic [23:0] busIn = '0;
  logic [23:0] pipeData = '0;
  logic [23:0] busOut;
  logic        busOe;

  always #10 clk = ~clk;

  host_mem_port u_dut (
    .clk(clk), .rstN(rstN), .clearN(clearN), .hostMode(hostMode), .wide(wide),
    .rdN(rdN), .wrN(wrN), .addr(addr), .upperSel(upperSel), .busIn(busIn),
    .pipeData(pipeData), .busOut(busOut), .busOe(busOe)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  task automatic check(string req, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [23:0] mMem [int];
  logic [23:0] mRead = '0;
  int          mWA = 0;
  bit          mWU = 1'b0;
  bit          prevRd = 1'b1, prevWr = 1'b1;
  logic [23:0] qOut [$];
  bit          qOe [$];

  function automatic logic [23:0] shape(logic [23:0] w, bit wd, bit up);
    if (wd) return w;
    if (up) return {16'h0, w[23:16]};
    return {8'h0, w[15:0]};
  endfunction

  function automatic logic [23:0] merge(logic [23:0] old, logic [23:0] d, bit wd, bit up);
    if (wd) return d;
    if (up) return {d[7:0], old[15:0]};
    return {old[23:16], d[15:0]};
  endfunction

  always @(posedge clk) begin
    logic [23:0] w;
    if (!rstN) begin
      prevRd = 1'b1; prevWr = 1'b1; mRead = '0;
    end else begin
      if (!clearN) mRead = '0;
      else if (hostMode && prevRd && !rdN) begin
        w = mMem.exists(int'(addr)) ? mMem[int'(addr)] : 24'hxxxxxx;
        mRead = shape(w, wide, upperSel);
      end
      if (hostMode && prevWr && !wrN) begin
        mWA = int'(addr); mWU = upperSel;
      end
      if (hostMode && !prevWr && wrN && clearN) begin
        w = mMem.exists(mWA) ? mMem[mWA] : 24'hxxxxxx;
        mMem[mWA] = merge(w, busIn, wide, mWU);
      end
      prevRd = rdN; prevWr = wrN;
    end
    qOut.push_back(mRead);
    qOe.push_back(rstN ? !rdN : 1'b0);
    if (qOut.size() > 3) begin
      void'(qOut.pop_front());
      void'(qOe.pop_front());
    end
  end

  // Compare against the model on every falling clock edge (three-cycle delay).
  always @(negedge clk) begin
    if (!done && qOut.size() == 3) begin
      check(curReq, "model busOut", busOut, hostMode ? qOut[0] : pipeData);
      check(curReq, "model busOe", {23'h0, busOe}, {23'h0, qOe[0]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic hostWrite(logic [9:0] a, bit up, logic [23:0] d);
    step(1); addr = a; upperSel = up; busIn = d;
    step(1); wrN = 1'b0;
    step(4); wrN = 1'b1;
    step(5);
  endtask

  task automatic hostRead(string req, logic [9:0] a, bit up, logic [23:0] exp);
    step(1); addr = a; upperSel = up;
    step(1); rdN = 1'b0;
    step(4);
    check(req, "read data", busOut, exp);
    check(req, "enable while reading", {23'h0, busOe}, 24'h1);
    rdN = 1'b1;
    step(4);
    check(req, "enable after read", {23'h0, busOe}, 24'h0);
  endtask

  initial begin
    #50000000;
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(3);
    rstN = 1'b1;
    step(2);
    check("R1", "busOut after reset", busOut, 24'h0);
    check("R1", "busOe after reset", {23'h0, busOe}, 24'h0);

    // R4: full-width access including both end addresses
    curReq = "R4";
    hostWrite(10'd5, 1'b0, 24'hABCDEF);
    hostWrite(10'd0, 1'b0, 24'h000001);
    hostWrite(10'd1023, 1'b0, 24'h123456);
    hostRead("R4", 10'd5, 1'b0, 24'hABCDEF);
    hostRead("R4", 10'd0, 1'b0, 24'h000001);
    hostRead("R4", 10'd1023, 1'b0, 24'h123456);

    // R2: address moves after capture; data must stay
    curReq = "R2";
    step(1); addr = 10'd5;
    step(1); rdN = 1'b0;
    step(4); addr = 10'd1023;
    step(4);
    check("R2", "held read after address change", busOut, 24'hABCDEF);
    rdN = 1'b1;
    step(4);

    // R3: address and data change during the low phase of the write strobe
    curReq = "R3";
    hostWrite(10'd9, 1'b0, 24'h111111);
    step(1); addr = 10'd7; busIn = 24'hAAAAAA;
    step(1); wrN = 1'b0;
    step(4); addr = 10'd9; busIn = 24'h0F0F0F;
    step(3); wrN = 1'b1;
    step(5);
    hostRead("R3", 10'd7, 1'b0, 24'h0F0F0F);
    hostRead("R3", 10'd9, 1'b0, 24'h111111);

    // R5 and R6: narrow reads
    step(1); wide = 1'b0;
    curReq = "R5";
    hostRead("R5", 10'd5, 1'b0, 24'h00CDEF);
    hostRead("R5", 10'd1023, 1'b0, 24'h003456);
    curReq = "R6";
    hostRead("R6", 10'd5, 1'b1, 24'h0000AB);
    hostRead("R6", 10'd1023, 1'b1, 24'h000012);

    // R7: narrow writes merge into the stored word
    curReq = "R7";
    hostWrite(10'd5, 1'b0, 24'hFF1234);
    step(1); wide = 1'b1;
    hostRead("R7", 10'd5, 1'b0, 24'hAB1234);
    step(1); wide = 1'b0;
    hostWrite(10'd5, 1'b1, 24'hFFFF77);
    step(1); wide = 1'b1;
    hostRead("R7", 10'd5, 1'b0, 24'h771234);

    // R8: pipeline mode passes data through, strobes only enable the bus
    curReq = "R8";
    step(1); hostMode = 1'b0; pipeData = 24'h13579B;
    step(2);
    check("R8", "pass-through", busOut, 24'h13579B);
    hostWrite(10'd5, 1'b0, 24'h555555);
    step(1); pipeData = 24'h2468AC; rdN = 1'b0;
    step(4);
    check("R8", "pass-through while reading", busOut, 24'h2468AC);
    check("R8", "enable follows read strobe", {23'h0, busOe}, 24'h1);
    rdN = 1'b1;
    step(4);
    step(1); hostMode = 1'b1;
    hostRead("R8", 10'd5, 1'b0, 24'h771234);

    // R9: clear blocks writes and zeroes reads
    curReq = "R9";
    step(1); clearN = 1'b0;
    step(3);
    hostWrite(10'd5, 1'b0, 24'h000000);
    hostRead("R9", 10'd5, 1'b0, 24'h000000);
    step(1); clearN = 1'b1;
    step(4);
    hostRead("R9", 10'd5, 1'b0, 24'h771234);

    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule